// File: doc/BRIEF.md
# Serial EEPROM Station Address Loader

This block fetches a 48-bit station address from a small three-wire serial EEPROM. The EEPROM also has a chip-select line, so four pins are used in all. The host starts the fetch by writing a reload opcode to the command input. All other opcodes are ignored.

The loader first reads EEPROM location 0 and compares the byte it gets with a signature value, 0xA5 by default. If the byte matches, the loader reads locations 1 to 6 and then updates the station address register in a single step. If the byte does not match, the EEPROM is treated as blank. The loader stops after that one read, and the station address register keeps its old value.

Status outputs report the result:
- a busy indication;
- a sticky "address valid" flag;
- a "load complete" flag for the most recent reload;
- a "load failed" flag for the most recent reload.

Each read is one serial frame. The frame is a command word followed by eight data bits. The serial clock is divided down from the system clock, and each of its half periods lasts `HALF_PERIOD` system clocks.

Top module: `macRomLoader`

## Requirements
- R1: A reload starts only at a clock edge where `cmdValid` is high, `cmdOp` equals 3'b111 and the block is idle. Any other opcode leaves every output unchanged.
- R2: `busy` rises at the accepting edge. It then stays high for exactly 38*`HALF_PERIOD` system clocks per frame: one frame on a failed load and seven frames on a successful one. Commands presented while busy are ignored.
- R3: Each frame holds `eeCs` high for 18 serial clock pulses. `eeDi` carries, MSB first: a start bit of 1, the read opcode 2'b10, and a 7-bit word address. These are followed by 8 don't-care bits. `eeDi` changes only while `eeSck` is low. `eeSck` is low whenever `eeCs` is low. Before each frame, `eeCs` stays low for at least 2*`HALF_PERIOD` system clocks.
- R4: The 8 data bits are taken from `eeDo` MSB first. Each bit is sampled at the rising serial clock edge of pulses 11 to 18.
- R5: The first frame reads address 0. If that byte is not 0xA5, no further frame follows, `loadFail` is set, and both `stationAddr` and `addrLoaded` keep their values.
- R6: On a signature match, frames follow for addresses 1 to 6 in that order. The byte at address 1 becomes `stationAddr[7:0]` and the byte at address 6 becomes `stationAddr[47:40]`. `stationAddr` changes only when the load completes.
- R7: `loadDone` and `loadFail` are both cleared when a reload is accepted. `loadDone` is set when a successful load completes. The two flags are never high together.
- R8: `addrLoaded` is set by the first successful load. It then stays set, including through later failed reloads.
- R9: After reset, all outputs are low: `busy`, the three flags, `stationAddr`, `eeCs`, `eeSck` and `eeDi`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Host command write strobe |
| cmdOp | input | 3 | Command opcode; 3'b111 requests a reload |
| busy | output | 1 | Reload sequence in progress |
| addrLoaded | output | 1 | Sticky: a valid station address has been loaded |
| loadDone | output | 1 | Most recent reload completed successfully |
| loadFail | output | 1 | Most recent reload failed the signature check |
| stationAddr | output | 48 | Loaded station address |
| eeCs | output | 1 | EEPROM chip select, active high |
| eeSck | output | 1 | EEPROM serial clock |
| eeDi | output | 1 | Serial data to the EEPROM |
| eeDo | input | 1 | Serial data from the EEPROM |

## Verification
A wrong phase counter or a wrong bit counter changes the length of `busy`. The reference model, which runs every clock, flags that on the first clock where `busy` differs. The EEPROM model also sees a frame whose pulse count or command word is wrong at the moment `eeCs` falls, which is at most 36*`HALF_PERIOD` clocks after the fault.

A wrong byte index or a wrong signature decision shows up as a wrong address sequence or a wrong number of frames. A wrong byte order in the data register shows up as a wrong `stationAddr` in the cycle the load completes. Flag faults show up one cycle after the accept edge or the finish edge.

// File: rtl/macRomLoader_pkg.sv
package macRomLoader_pkg;
  localparam int ADDR_W     = 7;
  localparam int DATA_W     = 8;
  localparam int CMD_W      = 1 + 2 + ADDR_W;
  localparam int FRAME_CLKS = CMD_W + DATA_W;
  localparam int MAC_BYTES  = 6;
  localparam int MAC_W      = MAC_BYTES * DATA_W;
  localparam logic [1:0] OP_READ = 2'b10;

  typedef struct packed {
    logic              loadCmd;
    logic              shiftOut;
    logic              sampleIn;
    logic              pushByte;
    logic              commit;
    logic [ADDR_W-1:0] addr;
  } strobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_GAP, ST_LOW, ST_HIGH} state_t;
endpackage

// File: rtl/macRomLoader_dp.sv
module macRomLoader_dp
  import macRomLoader_pkg::*;
#(
  parameter logic [DATA_W-1:0] SIGNATURE = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strobe,
  input  logic             eeDo,
  output logic             eeDi,
  output logic             sigMatch,
  output logic [MAC_W-1:0] stationAddr
);
  logic [CMD_W-1:0]  cmdSr;
  logic [DATA_W-1:0] rxSr;
  logic [MAC_W-1:0]  stage;
  logic [MAC_W-1:0]  nextStage;

  assign nextStage = {rxSr, stage[MAC_W-1:DATA_W]};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSr       <= '0;
      rxSr        <= '0;
      stage       <= '0;
      stationAddr <= '0;
    end else begin
      if (strobe.loadCmd)
        cmdSr <= {1'b1, OP_READ, strobe.addr};
      else if (strobe.shiftOut)
        cmdSr <= {cmdSr[CMD_W-2:0], 1'b0};
      if (strobe.sampleIn)
        rxSr <= {rxSr[DATA_W-2:0], eeDo};
      if (strobe.pushByte)
        stage <= nextStage;
      if (strobe.commit)
        stationAddr <= nextStage;
    end
  end

  assign eeDi     = cmdSr[CMD_W-1];
  assign sigMatch = (rxSr == SIGNATURE);
endmodule

// File: rtl/macRomLoader_ctrl.sv
module macRomLoader_ctrl
  import macRomLoader_pkg::*;
#(
  parameter int              HALF_PERIOD = 2,
  parameter int              OP_W        = 3,
  parameter logic [OP_W-1:0] RELOAD_OP   = 3'b111
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            cmdValid,
  input  logic [OP_W-1:0] cmdOp,
  input  logic            sigMatch,
  output strobe_t         strobe,
  output logic            eeCs,
  output logic            eeSck,
  output logic            busy,
  output logic            addrLoaded,
  output logic            loadDone,
  output logic            loadFail
);
  localparam int GAP_CYC = 2 * HALF_PERIOD;
  localparam int CNT_W   = $clog2(GAP_CYC) + 1;
  localparam int BIT_W   = $clog2(FRAME_CLKS) + 1;
  localparam int BYTE_W  = $clog2(MAC_BYTES + 1);

  state_t            state;
  logic [CNT_W-1:0]  cnt;
  logic [BIT_W-1:0]  bitIdx;
  logic [BYTE_W-1:0] byteIdx;
  logic gapEnd, halfEnd, lastBit, lastByte;

  assign gapEnd   = (cnt == CNT_W'(GAP_CYC - 1));
  assign halfEnd  = (cnt == CNT_W'(HALF_PERIOD - 1));
  assign lastBit  = (bitIdx == BIT_W'(FRAME_CLKS - 1));
  assign lastByte = (byteIdx == BYTE_W'(MAC_BYTES));

  always_comb begin
    strobe      = '0;
    strobe.addr = ADDR_W'(byteIdx);
    case (state)
      ST_GAP:  strobe.loadCmd  = gapEnd;
      ST_LOW:  strobe.sampleIn = halfEnd;
      ST_HIGH: begin
        strobe.shiftOut = halfEnd && !lastBit;
        strobe.pushByte = halfEnd && lastBit && (byteIdx != '0);
        strobe.commit   = halfEnd && lastBit && lastByte;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state      <= ST_IDLE;
      cnt        <= '0;
      bitIdx     <= '0;
      byteIdx    <= '0;
      eeCs       <= 1'b0;
      eeSck      <= 1'b0;
      busy       <= 1'b0;
      addrLoaded <= 1'b0;
      loadDone   <= 1'b0;
      loadFail   <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: if (cmdValid && cmdOp == RELOAD_OP) begin
          state    <= ST_GAP;
          cnt      <= '0;
          byteIdx  <= '0;
          busy     <= 1'b1;
          loadDone <= 1'b0;
          loadFail <= 1'b0;
        end
        ST_GAP: if (gapEnd) begin
          cnt    <= '0;
          bitIdx <= '0;
          eeCs   <= 1'b1;
          state  <= ST_LOW;
        end else cnt <= cnt + 1'b1;
        ST_LOW: if (halfEnd) begin
          cnt   <= '0;
          eeSck <= 1'b1;
          state <= ST_HIGH;
        end else cnt <= cnt + 1'b1;
        ST_HIGH: if (halfEnd) begin
          cnt   <= '0;
          eeSck <= 1'b0;
          if (lastBit) begin
            eeCs <= 1'b0;
            if (byteIdx == '0 && !sigMatch) begin
              state    <= ST_IDLE;
              busy     <= 1'b0;
              loadFail <= 1'b1;
            end else if (lastByte) begin
              state      <= ST_IDLE;
              busy       <= 1'b0;
              loadDone   <= 1'b1;
              addrLoaded <= 1'b1;
            end else begin
              byteIdx <= byteIdx + 1'b1;
              state   <= ST_GAP;
            end
          end else begin
            bitIdx <= bitIdx + 1'b1;
            state  <= ST_LOW;
          end
        end else cnt <= cnt + 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/macRomLoader.sv
module macRomLoader
  import macRomLoader_pkg::*;
#(
  parameter int                HALF_PERIOD = 2,
  parameter logic [2:0]        RELOAD_OP   = 3'b111,
  parameter logic [DATA_W-1:0] SIGNATURE   = 8'hA5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cmdValid,
  input  logic [2:0]       cmdOp,
  output logic             busy,
  output logic             addrLoaded,
  output logic             loadDone,
  output logic             loadFail,
  output logic [MAC_W-1:0] stationAddr,
  output logic             eeCs,
  output logic             eeSck,
  output logic             eeDi,
  input  logic             eeDo
);
  strobe_t strobe;
  logic    sigMatch;

  macRomLoader_ctrl #(
    .HALF_PERIOD(HALF_PERIOD), .OP_W(3), .RELOAD_OP(RELOAD_OP)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .sigMatch(sigMatch), .strobe(strobe), .eeCs(eeCs), .eeSck(eeSck),
    .busy(busy), .addrLoaded(addrLoaded), .loadDone(loadDone),
    .loadFail(loadFail)
  );

  macRomLoader_dp #(.SIGNATURE(SIGNATURE)) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .eeDo(eeDo),
    .eeDi(eeDi), .sigMatch(sigMatch), .stationAddr(stationAddr)
  );
endmodule

// File: rtl/macRomLoader_chk.sv
module macRomLoader_chk #(
  parameter int         HALF_PERIOD = 2,
  parameter logic [2:0] RELOAD_OP   = 3'b111
) (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic [2:0]  cmdOp,
  input logic        busy,
  input logic        addrLoaded,
  input logic        loadDone,
  input logic        loadFail,
  input logic [47:0] stationAddr,
  input logic        eeCs,
  input logic        eeSck,
  input logic        eeDi
);
  logic [15:0] lowCnt;

  always_ff @(posedge clk) begin
    if (!rstN || eeCs) lowCnt <= '0;
    else if (busy && lowCnt != 16'hFFFF) lowCnt <= lowCnt + 1'b1;
  end

  a_r1_start_needs_cmd: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdValid && cmdOp == RELOAD_OP));
  a_r2_cs_only_busy: assert property (@(posedge clk) disable iff (!rstN)
    eeCs |-> busy);
  a_r3_sck_low_deselected: assert property (@(posedge clk) disable iff (!rstN)
    !eeCs |-> !eeSck);
  a_r3_di_moves_sck_low: assert property (@(posedge clk) disable iff (!rstN)
    (eeCs && !$stable(eeDi)) |-> !eeSck);
  a_r3_gap_min: assert property (@(posedge clk) disable iff (!rstN)
    $rose(eeCs) |-> (lowCnt >= 16'(2 * HALF_PERIOD)));
  a_r6_addr_on_done: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(stationAddr) |-> $rose(loadDone));
  a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(loadDone && loadFail));
  a_r8_done_implies_loaded: assert property (@(posedge clk) disable iff (!rstN)
    loadDone |-> addrLoaded);
  a_r8_loaded_sticky: assert property (@(posedge clk) disable iff (!rstN)
    $past(addrLoaded) |-> addrLoaded);
endmodule

bind macRomLoader macRomLoader_chk #(.HALF_PERIOD(HALF_PERIOD), .RELOAD_OP(RELOAD_OP)) chk_i (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
  .addrLoaded(addrLoaded), .loadDone(loadDone), .loadFail(loadFail),
  .stationAddr(stationAddr), .eeCs(eeCs), .eeSck(eeSck), .eeDi(eeDi)
);

// File: tb/macRomLoader_tb.sv
module macRomLoader_tb_top;
  localparam int HALF  = 2;
  localparam int FRAME = 38 * HALF;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [2:0] cmdOp = '0;
  logic busy, addrLoaded, loadDone, loadFail, eeCs, eeSck, eeDi;
  logic eeDo = 1'b0;
  logic [47:0] stationAddr;

  always #4 clk = ~clk;

  macRomLoader #(.HALF_PERIOD(HALF)) dut_i (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .busy(busy),
    .addrLoaded(addrLoaded), .loadDone(loadDone), .loadFail(loadFail),
    .stationAddr(stationAddr), .eeCs(eeCs), .eeSck(eeSck), .eeDi(eeDi),
    .eeDo(eeDo)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // EEPROM model
  logic [7:0] mem [0:127];
  int bitCnt = 0;
  logic [9:0] cmdWord = '0;
  int frameAddr[$];
  int gap = 0;

  always @(posedge eeSck) if (eeCs) begin
    if (bitCnt < 10) cmdWord = {cmdWord[8:0], eeDi};
    bitCnt++;
  end
  always @(negedge eeSck) if (eeCs && bitCnt >= 10 && bitCnt < 18)
    eeDo = mem[cmdWord[6:0]][17 - bitCnt];
  always @(posedge eeCs) if (rstN) begin
    chk(gap >= 2 * HALF, "R3 chip-select low gap", gap, 2 * HALF);
    gap = 0;
    bitCnt = 0;
  end
  always @(negedge eeCs) if (rstN) begin
    chk(bitCnt == 18, "R3 pulses per frame", bitCnt, 18);
    chk(cmdWord[9:7] == 3'b110, "R3 start bit and read opcode", cmdWord[9:7], 3'b110);
    frameAddr.push_back(int'(cmdWord[6:0]));
  end

  // reference model
  int rem = 0;
  bit sigOk = 0;
  bit eLoaded = 0, eDone = 0, eFail = 0;
  logic [47:0] eAddr = '0;

  always @(posedge clk) begin
    if (busy && !eeCs) gap++;
    if (!rstN) begin
      rem = 0; eLoaded = 0; eDone = 0; eFail = 0; eAddr = '0;
    end else if (rem > 0) begin
      rem--;
      if (rem == 0) begin
        if (sigOk) begin
          eAddr = {mem[6], mem[5], mem[4], mem[3], mem[2], mem[1]};
          eLoaded = 1; eDone = 1;
        end else eFail = 1;
      end
    end else if (cmdValid && cmdOp == 3'b111) begin
      eDone = 0; eFail = 0;
      sigOk = (mem[0] == 8'hA5);
      rem = sigOk ? 7 * FRAME : FRAME;
    end
  end

  always @(negedge clk) if (rstN && !finished) begin
    chk(busy == (rem > 0), "R2 busy vs model", busy, rem > 0);
    chk(loadDone == eDone && loadFail == eFail, "R7 done/fail vs model",
        {loadDone, loadFail}, {eDone, eFail});
    chk(addrLoaded == eLoaded, "R8 addrLoaded vs model", addrLoaded, eLoaded);
    chk(stationAddr == eAddr, "R6 stationAddr vs model", stationAddr, eAddr);
  end

  task automatic issue(input logic [2:0] op);
    @(negedge clk); cmdValid = 1'b1; cmdOp = op;
    @(negedge clk); cmdValid = 1'b0; cmdOp = '0;
  endtask

  task automatic waitIdle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic checkSeq(input int n, input string tag);
    chk(frameAddr.size() == n, tag, frameAddr.size(), n);
    for (int i = 0; i < n && i < frameAddr.size(); i++)
      chk(frameAddr[i] == i, tag, frameAddr[i], i);
    frameAddr.delete();
  endtask

  initial begin
    for (int i = 0; i < 128; i++) mem[i] = 8'(i * 7 + 3);
    repeat (3) @(negedge clk);
    chk({busy, addrLoaded, loadDone, loadFail, eeCs, eeSck, eeDi} == '0,
        "R9 reset outputs", {busy, addrLoaded, loadDone, loadFail, eeCs, eeSck, eeDi}, 0);
    chk(stationAddr == '0, "R9 reset address", stationAddr, 0);
    rstN = 1'b1;

    // R1: other opcodes do nothing
    issue(3'b011); issue(3'b110);
    repeat (200) @(negedge clk);
    chk(busy == 0, "R1 non-reload opcode ignored", busy, 0);
    checkSeq(0, "R1 no frames for other opcodes");

    // R5: blank EEPROM
    mem[0] = 8'h5A;
    issue(3'b111); waitIdle();
    checkSeq(1, "R5 single frame on bad signature");
    chk(loadFail == 1 && loadDone == 0, "R5 fail flag", {loadDone, loadFail}, 2'b01);
    chk(stationAddr == 0 && addrLoaded == 0, "R5 address untouched", stationAddr, 0);

    // R6: success, with commands while busy (R2)
    mem[0] = 8'hA5;
    mem[1] = 8'h11; mem[2] = 8'h22; mem[3] = 8'h33;
    mem[4] = 8'h44; mem[5] = 8'h55; mem[6] = 8'h66;
    issue(3'b111);
    repeat (100) @(negedge clk);
    issue(3'b111); issue(3'b001);
    waitIdle();
    checkSeq(7, "R6 addresses 0..6 in order, R2 busy command ignored");
    chk(stationAddr == 48'h665544332211, "R6 byte order", stationAddr, 48'h665544332211);
    chk(loadDone == 1 && loadFail == 0, "R7 done after success", {loadDone, loadFail}, 2'b10);
    chk(addrLoaded == 1, "R8 set after success", addrLoaded, 1);

    // R5/R8: near-miss signature after success
    mem[0] = 8'hA4;
    issue(3'b111); waitIdle();
    checkSeq(1, "R5 near-miss signature");
    chk(stationAddr == 48'h665544332211, "R5 address kept", stationAddr, 48'h665544332211);
    chk(addrLoaded == 1, "R8 sticky over failure", addrLoaded, 1);
    chk(loadDone == 0 && loadFail == 1, "R7 cleared then fail", {loadDone, loadFail}, 2'b01);

    // R4: bit order patterns
    mem[0] = 8'hA5;
    mem[1] = 8'h80; mem[2] = 8'h01; mem[3] = 8'hFF;
    mem[4] = 8'h00; mem[5] = 8'h7E; mem[6] = 8'hC3;
    issue(3'b111); waitIdle();
    checkSeq(7, "R4 frame sequence");
    chk(stationAddr == 48'hC37E00FF0180, "R4 MSB-first sampling", stationAddr, 48'hC37E00FF0180);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule